// File: doc/BRIEF.md
# Vector Bitwise Test Flag Unit

This execution unit receives two vector source operands and reports processor status flags from a bitwise test of those operands. It writes no data result and leaves both operands untouched. One flag (zero) says whether the two sources share any set bit. The other (carry) says whether the second source has a set bit that the first source lacks. The four remaining arithmetic flags are always cleared. A length input picks a 128-bit or a 256-bit test width. In the 128-bit width the upper half of both operands is masked away, so stale upper data cannot reach either flag.

Operands enter through a valid/ready handshake. A two-stage OR-reduction tree does the two zero-detects: registered 16-bit group ORs, then the final OR into the flag register. An encoding-legality check runs on the extended-encoding forms. It requires the 4-bit register-specifier field to read all ones. Any other value replaces the flag update with a one-cycle invalid-opcode pulse. The legacy encoding skips this check.

A four-state controller sequences each operation:
- `ST_IDLE` accepts operands.
- `ST_REDUCE` holds the registered group ORs.
- `ST_POST` presents the new flags for one cycle.
- `ST_FAULT` presents the exception for one cycle.

The transitions are:
- IDLE→REDUCE on an accepted operand.
- REDUCE→POST for a legal encoding.
- REDUCE→FAULT for an illegal one.
- POST→IDLE and FAULT→IDLE unconditionally.

Top module: `vtest_flag_unit`

## Requirements
- R1: flags_out[3] (zero flag) becomes 1 exactly when (src_a AND src_b) over the tested width is all zeros, otherwise 0; all-zero sources give zero=1 and carry=1.
- R2: flags_out[0] (carry flag) becomes 1 exactly when (src_b AND NOT src_a) over the tested width is all zeros, otherwise 0; src_a all zeros with src_b all ones gives zero=1 and carry=0.
- R3: flags_out is ordered {OF,SF,ZF,AF,PF,CF} from bit 5 down to bit 0, and bits 5, 4, 2 and 1 are always 0 after an update.
- R4: With wide_mode=0 only bits 127:0 of both sources are tested and bits 255:128 have no effect; with wide_mode=1 bits 255:0 are tested.
- R5: An operation accepted with ext_enc=1 and spec_field != 4'b1111 pulses undef_exc instead of flags_valid, and flags_out and the pred_* outputs keep their previous values.
- R6: An operation accepted with ext_enc=0 never raises undef_exc, whatever spec_field holds.
- R7: An operand is accepted on a rising edge where in_valid and in_ready are both 1. flags_valid or undef_exc is then high for exactly one cycle, beginning at the second rising edge after the accepting edge, and never in the cycle right after the accepting edge. The two outputs are never high together.
- R8: in_ready is 1 only in the idle state. It is 0 from the accepting edge until the result pulse ends, and in_valid and the operand inputs are ignored while it is 0.
- R9: pred_zero equals the zero flag, pred_carry equals the carry flag, and pred_nzc is 1 only when both are 0; all three update together with flags_out.
- R10: After reset, flags_out and the pred_* outputs are 0, flags_valid and undef_exc are 0, and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and controls are presented |
| in_ready | output | 1 | Unit is idle and will accept operands |
| src_a | input | 256 | First source operand |
| src_b | input | 256 | Second source operand |
| wide_mode | input | 1 | 1 selects the 256-bit test, 0 the 128-bit test |
| ext_enc | input | 1 | 1 marks an extended-encoding form that is subject to the legality check |
| spec_field | input | 4 | Register-specifier field of the extended encoding |
| flags_out | output | 6 | Flag register {OF,SF,ZF,AF,PF,CF} |
| flags_valid | output | 1 | One-cycle pulse marking a flag update |
| undef_exc | output | 1 | One-cycle invalid-opcode pulse |
| pred_zero | output | 1 | Zero predicate |
| pred_carry | output | 1 | Carry predicate |
| pred_nzc | output | 1 | Neither zero nor carry |

## Verification
A corrupted group-OR register appears as a wrong zero or carry flag in the `ST_POST` cycle, two edges after acceptance. A bad mask shows up only in operand pairs that differ in the upper half while the 128-bit width is selected. A controller stuck in or skipping a state shows at once: in_ready stays low, the pulse arrives a cycle early or late, or both pulses appear. A wrong legality latch appears in the same pulse cycle as the wrong choice of pulse, or as flags_out changing during an exception. Operand vectors are chosen so that each flag, each half of the vector and each encoding path toggles on its own.

// File: rtl/vtf_pkg.sv
package vtf_pkg;

    localparam int VEC_W    = 256;
    localparam int NARROW_W = 128;
    localparam int GROUP_W  = 16;
    localparam int SPEC_W   = 4;
    localparam int FLAG_W   = 6;

    // Bit positions within the flag register {OF,SF,ZF,AF,PF,CF}
    localparam int FLG_CF = 0;
    localparam int FLG_PF = 1;
    localparam int FLG_AF = 2;
    localparam int FLG_ZF = 3;
    localparam int FLG_SF = 4;
    localparam int FLG_OF = 5;

    localparam logic [SPEC_W-1:0] SPEC_LEGAL = '1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REDUCE,
        ST_POST,
        ST_FAULT
    } vtf_state_e;

endpackage

// File: rtl/vtf_operand_mix.sv
module vtf_operand_mix #(
    parameter int VEC_W    = 256,
    parameter int NARROW_W = 128
) (
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    input  logic             wide_mode,
    output logic [VEC_W-1:0] and_term,
    output logic [VEC_W-1:0] andn_term
);
    localparam int UPPER_W = VEC_W - NARROW_W;

    logic [VEC_W-1:0] lane_mask;

    // Narrow width clears the upper lanes so stale data cannot reach a flag
    always_comb begin
        if (wide_mode) begin
            lane_mask = '1;
        end else begin
            lane_mask = {{UPPER_W{1'b0}}, {NARROW_W{1'b1}}};
        end
        and_term  = src_a & src_b & lane_mask;
        andn_term = ~src_a & src_b & lane_mask;
    end

endmodule

// File: rtl/vtf_group_or.sv
module vtf_group_or #(
    parameter int VEC_W   = 256,
    parameter int GROUP_W = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             load,
    input  logic [VEC_W-1:0]                 vec,
    output logic [(VEC_W/GROUP_W)-1:0]       grp_q
);
    localparam int NGRP = VEC_W / GROUP_W;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                grp_q[g] <= 1'b0;
            end else if (load) begin
                grp_q[g] <= |vec[g*GROUP_W +: GROUP_W];
            end
        end
    end

endmodule

// File: rtl/vtf_ctrl.sv
module vtf_ctrl
    import vtf_pkg::*;
#(
    parameter int SPEC_BITS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 ext_enc,
    input  logic [SPEC_BITS-1:0] spec_field,
    output logic                 in_ready,
    output logic                 fire,
    output logic                 load_flags,
    output logic                 flags_valid,
    output logic                 undef_exc
);
    vtf_state_e state_q, state_d;
    logic       fault_q;
    logic       illegal;

    assign illegal = ext_enc && (spec_field != SPEC_W'(SPEC_LEGAL));
    assign fire    = in_valid && (state_q == ST_IDLE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            fault_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (fire) begin
                fault_q <= illegal;
            end
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (fire) state_d = ST_REDUCE;
            ST_REDUCE: state_d = fault_q ? ST_FAULT : ST_POST;
            ST_POST:   state_d = ST_IDLE;
            ST_FAULT:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        in_ready    = 1'b0;
        load_flags  = 1'b0;
        flags_valid = 1'b0;
        undef_exc   = 1'b0;
        unique case (state_q)
            ST_IDLE:   in_ready   = 1'b1;
            ST_REDUCE: load_flags = !fault_q;
            ST_POST:   flags_valid = 1'b1;
            ST_FAULT:  undef_exc  = 1'b1;
        endcase
    end

    assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_valid || undef_exc) |-> $past(fire, 2));
    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_valid || undef_exc) |=> !(flags_valid || undef_exc));
    assert_exc_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        undef_exc |-> $past(fire && ext_enc && (spec_field != SPEC_W'(SPEC_LEGAL)), 2));
    assert_legacy_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !ext_enc) |=> ##1 !undef_exc);
    assert_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !in_ready);

endmodule

// File: rtl/vtest_flag_unit.sv
module vtest_flag_unit
    import vtf_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [VEC_W-1:0]   src_a,
    input  logic [VEC_W-1:0]   src_b,
    input  logic               wide_mode,
    input  logic               ext_enc,
    input  logic [SPEC_W-1:0]  spec_field,
    output logic [FLAG_W-1:0]  flags_out,
    output logic               flags_valid,
    output logic               undef_exc,
    output logic               pred_zero,
    output logic               pred_carry,
    output logic               pred_nzc
);
    localparam int NGRP = VEC_W / GROUP_W;

    logic [VEC_W-1:0]  and_term, andn_term;
    logic [NGRP-1:0]   and_grp, andn_grp;
    logic              fire, load_flags;
    logic [FLAG_W-1:0] flags_d;

    vtf_operand_mix #(.VEC_W(VEC_W), .NARROW_W(NARROW_W)) u_mix (
        .src_a     (src_a),
        .src_b     (src_b),
        .wide_mode (wide_mode),
        .and_term  (and_term),
        .andn_term (andn_term)
    );

    vtf_group_or #(.VEC_W(VEC_W), .GROUP_W(GROUP_W)) u_and_or (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (fire),
        .vec   (and_term),
        .grp_q (and_grp)
    );

    vtf_group_or #(.VEC_W(VEC_W), .GROUP_W(GROUP_W)) u_andn_or (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (fire),
        .vec   (andn_term),
        .grp_q (andn_grp)
    );

    vtf_ctrl #(.SPEC_BITS(SPEC_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .ext_enc     (ext_enc),
        .spec_field  (spec_field),
        .in_ready    (in_ready),
        .fire        (fire),
        .load_flags  (load_flags),
        .flags_valid (flags_valid),
        .undef_exc   (undef_exc)
    );

    // Second reduction stage; the other four flags are forced clear
    always_comb begin
        flags_d         = '0;
        flags_d[FLG_ZF] = ~|and_grp;
        flags_d[FLG_CF] = ~|andn_grp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_out  <= '0;
            pred_zero  <= 1'b0;
            pred_carry <= 1'b0;
            pred_nzc   <= 1'b0;
        end else if (load_flags) begin
            flags_out  <= flags_d;
            pred_zero  <= flags_d[FLG_ZF];
            pred_carry <= flags_d[FLG_CF];
            pred_nzc   <= !flags_d[FLG_ZF] && !flags_d[FLG_CF];
        end
    end

    assert_clear_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
        flags_valid |-> (!flags_out[FLG_OF] && !flags_out[FLG_SF]
                         && !flags_out[FLG_AF] && !flags_out[FLG_PF]));
    assert_hold_on_exc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        undef_exc |-> ($stable(flags_out) && $stable(pred_nzc)));
    assert_predicates_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flags_valid |-> (pred_zero == flags_out[FLG_ZF] && pred_carry == flags_out[FLG_CF]
                         && pred_nzc == (!flags_out[FLG_ZF] && !flags_out[FLG_CF])));

endmodule

// File: tb/vtest_flag_unit_test.sv
`timescale 1ns/1ps
module vtest_flag_unit_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [255:0] src_a = '0;
    logic [255:0] src_b = '0;
    logic         wide_mode = 1'b0;
    logic         ext_enc = 1'b0;
    logic [3:0]   spec_field = '0;
    logic [5:0]   flags_out;
    logic         flags_valid, undef_exc, pred_zero, pred_carry, pred_nzc;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    vtest_flag_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .src_a(src_a), .src_b(src_b), .wide_mode(wide_mode), .ext_enc(ext_enc),
        .spec_field(spec_field), .flags_out(flags_out), .flags_valid(flags_valid),
        .undef_exc(undef_exc), .pred_zero(pred_zero), .pred_carry(pred_carry),
        .pred_nzc(pred_nzc)
    );

    typedef struct packed {
        logic [255:0] a;
        logic [255:0] b;
        logic         wide;
        logic         ext;
        logic [3:0]   spec;
        logic [5:0]   flags;
        logic         exc;
    } vec_t;

    // flags = {OF,SF,ZF,AF,PF,CF}: 0x09 zero+carry, 0x08 zero, 0x01 carry
    localparam int NVEC = 10;
    localparam vec_t TBL [NVEC] = '{
        '{a: '0, b: '0, wide: 1'b1, ext: 1'b1, spec: 4'hF, flags: 6'h09, exc: 1'b0},
        '{a: '0, b: '1, wide: 1'b1, ext: 1'b1, spec: 4'hF, flags: 6'h08, exc: 1'b0},
        '{a: '1, b: '1, wide: 1'b1, ext: 1'b0, spec: 4'h3, flags: 6'h01, exc: 1'b0},
        '{a: {16{16'h00FF}}, b: {16{16'h0F0F}}, wide: 1'b1, ext: 1'b1, spec: 4'hF, flags: 6'h00, exc: 1'b0},
        '{a: '0, b: {{128{1'b1}}, 128'h0}, wide: 1'b0, ext: 1'b0, spec: 4'h0, flags: 6'h09, exc: 1'b0},
        '{a: '0, b: {{128{1'b1}}, 128'h0}, wide: 1'b1, ext: 1'b1, spec: 4'hF, flags: 6'h08, exc: 1'b0},
        '{a: {1'b1, 255'h0}, b: {1'b1, 255'h0}, wide: 1'b1, ext: 1'b1, spec: 4'hF, flags: 6'h01, exc: 1'b0},
        '{a: '0, b: {128'h0, 1'b1, 127'h0}, wide: 1'b0, ext: 1'b0, spec: 4'h0, flags: 6'h08, exc: 1'b0},
        '{a: '0, b: '0, wide: 1'b1, ext: 1'b1, spec: 4'hE, flags: 6'h08, exc: 1'b1},
        '{a: '1, b: 256'h1, wide: 1'b0, ext: 1'b1, spec: 4'hF, flags: 6'h01, exc: 1'b0}
    };

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Presents one operation and returns at the negedge of the pulse cycle
    task automatic issue(input logic [255:0] a, input logic [255:0] b,
                         input logic w, input logic e, input logic [3:0] s);
        @(negedge clk);
        src_a = a; src_b = b; wide_mode = w; ext_enc = e; spec_field = s;
        in_valid = 1'b1;
        chk(64'(in_ready), 64'd1, "R8 ready while idle");
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk(64'(flags_valid || undef_exc), 64'd0, "R7 no pulse one edge after accept");
        chk(64'(in_ready), 64'd0, "R8 busy after accept");
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic settle();
        @(posedge clk);
        @(negedge clk);
        chk(64'(flags_valid || undef_exc), 64'd0, "R7 pulse lasts one cycle");
        chk(64'(in_ready), 64'd1, "R8 ready again");
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        chk(64'(flags_out), 64'd0, "R10 flags after reset");
        chk(64'({pred_zero, pred_carry, pred_nzc}), 64'd0, "R10 predicates after reset");
        chk(64'({flags_valid, undef_exc}), 64'd0, "R10 pulses after reset");
        chk(64'(in_ready), 64'd1, "R10 ready after reset");
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            issue(TBL[i].a, TBL[i].b, TBL[i].wide, TBL[i].ext, TBL[i].spec);
            chk(64'(undef_exc), 64'(TBL[i].exc), $sformatf("R5/R6 exception row %0d", i));
            chk(64'(flags_valid), 64'(!TBL[i].exc), $sformatf("R7 valid row %0d", i));
            chk(64'(flags_out), 64'(TBL[i].flags), $sformatf("R1/R2/R3/R4 flags row %0d", i));
            chk(64'({pred_zero, pred_carry, pred_nzc}),
                64'({TBL[i].flags[3], TBL[i].flags[0], !TBL[i].flags[3] && !TBL[i].flags[0]}),
                $sformatf("R9 predicates row %0d", i));
            settle();
        end

        // R5: illegal specifier in the 128-bit extended form keeps flags (last 0x01)
        issue('0, '0, 1'b0, 1'b1, 4'h0);
        chk(64'(undef_exc), 64'd1, "R5 narrow illegal raises exception");
        chk(64'(flags_valid), 64'd0, "R7 no valid with exception");
        chk(64'(flags_out), 64'h01, "R5 flags unchanged");
        settle();

        // R6: legacy form with an odd specifier value
        issue('1, '0, 1'b1, 1'b0, 4'h7);
        chk(64'(undef_exc), 64'd0, "R6 legacy never faults");
        chk(64'(flags_out), 64'h09, "R1 R2 disjoint zero b");
        settle();

        // R8: operands presented while busy are ignored
        @(negedge clk);
        src_a = '0; src_b = '0; wide_mode = 1'b1; ext_enc = 1'b0; spec_field = 4'h0;
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        src_a = '1; src_b = '1; ext_enc = 1'b1; spec_field = 4'h2;
        chk(64'(in_ready), 64'd0, "R8 busy while new operands shown");
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk(64'(flags_valid), 64'd1, "R8 first operation completes");
        chk(64'(flags_out), 64'h09, "R8 busy-cycle operands ignored");
        chk(64'(undef_exc), 64'd0, "R8 busy-cycle illegal encoding ignored");
        settle();
        repeat (3) begin
            @(negedge clk);
            chk(64'(flags_valid || undef_exc), 64'd0, "R8 no extra operation");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule